// File: doc/BRIEF.md
# Event State Buffer Load Controller

This block keeps a two-bit pending/queued (PQ) event-state pair for every entry of a small table of event queue descriptors. Each descriptor has a notification field and an escalation field. Software reaches both through memory-mapped loads. The operation is chosen by the load address and never by data. A load can perform end-of-interrupt, read the state, or force the state to a given value. Stores are refused.

A separate trigger input models an event arriving at a descriptor. If the descriptor is not flagged for unconditional notification, the event passes through the notification PQ pair. The pair coalesces repeated events, and a notification leaves only when the state machine allows it. The valid and unconditional-notify flags come in as static configuration vectors. The PQ pairs live in registers inside the block.

Top module: `esb_load_ctrl`

## Requirements
- R1: Address map. The descriptor index is `addr >> (PAGE_SHIFT+1)`. Address bit PAGE_SHIFT selects the field: 0 selects notification and 1 selects escalation. The operation offset is `addr[11:0]`. PAGE_SHIFT is 12 or 16.
- R2: `rsp_valid_o` is high in the cycle after each request, loads and stores alike, and low otherwise.
- R3: A load at offset 0x000–0x7FF performs end-of-interrupt. It returns the old Q in bit 0 with all other bits zero. The new state is 10 if Q was 1, else 00. P is bit 1 and Q is bit 0.
- R4: A load at offset 0x800–0xBFF returns the current PQ in bits [1:0] and leaves it unchanged.
- R5: A load at offset 0xC00–0xFFF sets PQ to offset bits [9:8]. It returns the old PQ in bits [1:0].
- R6: A store sets `rsp_err_o` with data zero and changes no state.
- R7: A load whose size is not 8 bytes sets `rsp_err_o`, returns all ones and changes no state.
- R8: A valid-size load that targets a descriptor with its valid flag clear, or an index at or above NUM_DESC, returns all ones with `rsp_err_o` low and changes no state.
- R9: A trigger on a valid descriptor with unconditional notify clear updates the notification PQ as follows: 00 goes to 10 and notifies; 10 and 11 go to 11 with no notify; 01 stays 01 with no notify. `notify_o` follows one cycle later.
- R10: A trigger on a descriptor with unconditional notify set always notifies and leaves its PQ unchanged.
- R11: A trigger on an invalid or out-of-range descriptor is ignored: no notify and no state change.
- R12: If a load and a trigger hit the same notification field in one cycle, the load is applied first and the trigger then acts on its result.
- R13: After reset every PQ pair is 00 and `rsp_valid_o` and `notify_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| desc_valid_i | input | NUM_DESC | Valid flag per descriptor |
| ucond_i | input | NUM_DESC | Unconditional-notify flag per descriptor |
| req_valid_i | input | 1 | Access request strobe |
| req_write_i | input | 1 | 1 for store, 0 for load |
| req_addr_i | input | ADDR_W | Byte address in the mapped region |
| req_size_i | input | 4 | Access size in bytes |
| rsp_valid_o | output | 1 | Response strobe |
| rsp_err_o | output | 1 | Access rejected (store or wrong size) |
| rsp_data_o | output | 64 | Load return value |
| trig_valid_i | input | 1 | Event trigger strobe |
| trig_idx_i | input | IDX_W | Triggered descriptor index |
| notify_o | output | 1 | Notification forwarded |
| notify_idx_o | output | IDX_W | Descriptor of the notification |

## Verification
Responses and notifications are registered once. Both are due in the cycle after the edge that samples the request or trigger. State written at that same edge can be read by the very next load. The bench drives each stimulus on a falling edge and holds it across one rising edge. It samples `rsp_*` and `notify_*` just after that edge and then drops the strobes. Every side effect that a load or trigger is said to have, or not to have, is confirmed with a following read-state load. For R8 on an invalid descriptor, the bench sets the valid flag and then reads the field.

// File: rtl/esb_pkg.sv
package esb_pkg;
  typedef logic [1:0] pq_t;  // [1]=P, [0]=Q

  localparam pq_t PQ_RESET = 2'b00;

  typedef enum logic [1:0] {
    OP_EOI = 2'd0,
    OP_GET = 2'd1,
    OP_SET = 2'd2
  } esb_op_e;

  function automatic pq_t pq_trig_next(pq_t s);
    case (s)
      2'b00:   return 2'b10;
      2'b01:   return 2'b01;
      default: return 2'b11;
    endcase
  endfunction

  function automatic logic pq_trig_notify(pq_t s);
    return (s == 2'b00);
  endfunction

  function automatic pq_t pq_eoi_next(pq_t s);
    return s[0] ? 2'b10 : 2'b00;
  endfunction
endpackage

// File: rtl/esb_addr_decode.sv
module esb_addr_decode
  import esb_pkg::*;
#(
  parameter int PAGE_SHIFT = 12,
  parameter int NUM_DESC   = 6,
  parameter int IDX_W      = 3,
  parameter int ADDR_W     = 16
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              in_range_o,
  output logic              sel_esc_o,
  output esb_op_e           op_o,
  output pq_t               set_val_o
);
  logic [11:0] offs;

  assign offs       = addr_i[11:0];
  assign idx_o      = addr_i[ADDR_W-1 -: IDX_W];
  assign sel_esc_o  = addr_i[PAGE_SHIFT];
  assign in_range_o = (int'(idx_o) < NUM_DESC);
  assign set_val_o  = offs[9:8];

  always_comb begin
    if (!offs[11])      op_o = OP_EOI;
    else if (!offs[10]) op_o = OP_GET;
    else                op_o = OP_SET;
  end
endmodule

// File: rtl/esb_desc_table.sv
module esb_desc_table
  import esb_pkg::*;
#(
  parameter int NUM_DESC = 6,
  parameter int IDX_W    = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     mmio_we_i,
  input  logic [IDX_W-1:0]         mmio_idx_i,
  input  logic                     mmio_esc_i,
  input  pq_t                      mmio_val_i,
  input  logic                     trig_we_i,
  input  logic [IDX_W-1:0]         trig_idx_i,
  input  pq_t                      trig_val_i,
  output logic [NUM_DESC-1:0][1:0] pq_n_o,
  output logic [NUM_DESC-1:0][1:0] pq_e_o
);
  for (genvar i = 0; i < NUM_DESC; i++) begin : g_ent
    logic hit_m, hit_t;
    assign hit_m = mmio_we_i && (int'(mmio_idx_i) == i);
    assign hit_t = trig_we_i && (int'(trig_idx_i) == i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pq_n_o[i] <= PQ_RESET;
        pq_e_o[i] <= PQ_RESET;
      end else begin
        // trigger value already folds in a same-cycle load
        if (hit_t)                   pq_n_o[i] <= trig_val_i;
        else if (hit_m && !mmio_esc_i) pq_n_o[i] <= mmio_val_i;
        if (hit_m && mmio_esc_i)     pq_e_o[i] <= mmio_val_i;
      end
    end
  end
endmodule

// File: rtl/esb_trigger_unit.sv
module esb_trigger_unit
  import esb_pkg::*;
#(
  parameter int NUM_DESC = 6,
  parameter int IDX_W    = 3
) (
  input  logic                trig_valid_i,
  input  logic [IDX_W-1:0]    trig_idx_i,
  input  logic [NUM_DESC-1:0] desc_valid_i,
  input  logic [NUM_DESC-1:0] ucond_i,
  input  pq_t                 pq_cur_i,
  output logic                we_o,
  output pq_t                 val_o,
  output logic                notify_o
);
  logic ok, uc;

  always_comb begin
    ok = 1'b0;
    uc = 1'b0;
    for (int i = 0; i < NUM_DESC; i++) begin
      if (int'(trig_idx_i) == i) begin
        ok = trig_valid_i && desc_valid_i[i];
        uc = ucond_i[i];
      end
    end
    val_o    = pq_trig_next(pq_cur_i);
    we_o     = ok && !uc && (val_o != pq_cur_i);
    notify_o = ok && (uc || pq_trig_notify(pq_cur_i));
  end
endmodule

// File: rtl/esb_load_ctrl.sv
module esb_load_ctrl
  import esb_pkg::*;
#(
  parameter int NUM_DESC   = 6,
  parameter int PAGE_SHIFT = 12,
  localparam int IDX_W     = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1,
  localparam int ADDR_W    = PAGE_SHIFT + 1 + IDX_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_DESC-1:0] desc_valid_i,
  input  logic [NUM_DESC-1:0] ucond_i,
  input  logic                req_valid_i,
  input  logic                req_write_i,
  input  logic [ADDR_W-1:0]   req_addr_i,
  input  logic [3:0]          req_size_i,
  output logic                rsp_valid_o,
  output logic                rsp_err_o,
  output logic [63:0]         rsp_data_o,
  input  logic                trig_valid_i,
  input  logic [IDX_W-1:0]    trig_idx_i,
  output logic                notify_o,
  output logic [IDX_W-1:0]    notify_idx_o
);
  logic [IDX_W-1:0]         dec_idx;
  logic                     dec_in_range, dec_esc;
  esb_op_e                  dec_op;
  pq_t                      dec_set;
  logic [NUM_DESC-1:0][1:0] pq_n_w, pq_e_w;

  esb_addr_decode #(
    .PAGE_SHIFT(PAGE_SHIFT), .NUM_DESC(NUM_DESC), .IDX_W(IDX_W), .ADDR_W(ADDR_W)
  ) u_dec (
    .addr_i(req_addr_i), .idx_o(dec_idx), .in_range_o(dec_in_range),
    .sel_esc_o(dec_esc), .op_o(dec_op), .set_val_o(dec_set)
  );

  logic  acc_load, hit, mmio_we;
  pq_t   cur, nxt;
  logic [63:0] ret;

  always_comb begin
    acc_load = req_valid_i && !req_write_i && (req_size_i == 4'd8);
    hit      = 1'b0;
    cur      = PQ_RESET;
    for (int i = 0; i < NUM_DESC; i++) begin
      if (int'(dec_idx) == i) begin
        hit = acc_load && desc_valid_i[i];
        cur = dec_esc ? pq_e_w[i] : pq_n_w[i];
      end
    end
    nxt = cur;
    ret = '0;
    case (dec_op)
      OP_EOI: begin nxt = pq_eoi_next(cur); ret[0] = cur[0]; end
      OP_GET: ret[1:0] = cur;
      default: begin nxt = dec_set; ret[1:0] = cur; end
    endcase
    mmio_we = hit && (nxt != cur);  // write back only on change
  end

  // notification field seen by the trigger, after any same-cycle load
  pq_t   trig_cur;
  logic  trig_we, trig_ntf;
  pq_t   trig_val;

  always_comb begin
    trig_cur = PQ_RESET;
    for (int i = 0; i < NUM_DESC; i++)
      if (int'(trig_idx_i) == i) trig_cur = pq_n_w[i];
    if (mmio_we && !dec_esc && (dec_idx == trig_idx_i)) trig_cur = nxt;
  end

  esb_trigger_unit #(.NUM_DESC(NUM_DESC), .IDX_W(IDX_W)) u_trig (
    .trig_valid_i(trig_valid_i), .trig_idx_i(trig_idx_i),
    .desc_valid_i(desc_valid_i), .ucond_i(ucond_i), .pq_cur_i(trig_cur),
    .we_o(trig_we), .val_o(trig_val), .notify_o(trig_ntf)
  );

  esb_desc_table #(.NUM_DESC(NUM_DESC), .IDX_W(IDX_W)) u_tab (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .mmio_we_i(mmio_we), .mmio_idx_i(dec_idx), .mmio_esc_i(dec_esc),
    .mmio_val_i(nxt),
    .trig_we_i(trig_we), .trig_idx_i(trig_idx_i), .trig_val_i(trig_val),
    .pq_n_o(pq_n_w), .pq_e_o(pq_e_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o  <= 1'b0;
      rsp_err_o    <= 1'b0;
      rsp_data_o   <= '0;
      notify_o     <= 1'b0;
      notify_idx_o <= '0;
    end else begin
      rsp_valid_o  <= req_valid_i;
      notify_o     <= trig_ntf;
      notify_idx_o <= trig_idx_i;
      if (req_valid_i) begin
        if (req_write_i) begin
          rsp_err_o  <= 1'b1;
          rsp_data_o <= '0;
        end else if (!acc_load) begin
          rsp_err_o  <= 1'b1;
          rsp_data_o <= '1;
        end else begin
          rsp_err_o  <= 1'b0;
          rsp_data_o <= hit ? ret : '1;
        end
      end
    end
  end

  a_r2_rsp_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  a_r2_no_rsp_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
  a_r6_store_no_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i && !trig_valid_i)
      |=> (rsp_err_o && $stable(pq_n_w) && $stable(pq_e_w)));
  a_r8_miss_all_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_load && !dec_in_range) |=> (rsp_data_o == '1 && !rsp_err_o));
  a_r9_notify_sets_p: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (notify_o && !$past(trig_valid_i && ucond_i[trig_idx_i]))
      |-> pq_n_w[notify_idx_o][1]);
  a_r3_small_return: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_err_o && rsp_data_o != '1) |-> (rsp_data_o[63:2] == '0));
endmodule

// File: tb/esb_load_ctrl_bench.sv
module esb_load_ctrl_bench;
  localparam int N   = 6;
  localparam int PS  = 12;
  localparam int IW  = 3;
  localparam int AW  = PS + 1 + IW;
  localparam logic [63:0] ONES = '1;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] dvalid = 6'b011111;  // desc 5 invalid
  logic [N-1:0] ucond  = 6'b000100;  // desc 2 unconditional
  logic req_v = 0, req_w = 0;
  logic [AW-1:0] req_a = '0;
  logic [3:0] req_sz = 4'd8;
  logic rsp_v, rsp_e;
  logic [63:0] rsp_d;
  logic trig_v = 0;
  logic [IW-1:0] trig_i = '0;
  logic ntf;
  logic [IW-1:0] ntf_i;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  esb_load_ctrl #(.NUM_DESC(N), .PAGE_SHIFT(PS)) u_esb_load_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .desc_valid_i(dvalid), .ucond_i(ucond),
    .req_valid_i(req_v), .req_write_i(req_w), .req_addr_i(req_a),
    .req_size_i(req_sz), .rsp_valid_o(rsp_v), .rsp_err_o(rsp_e),
    .rsp_data_o(rsp_d), .trig_valid_i(trig_v), .trig_idx_i(trig_i),
    .notify_o(ntf), .notify_idx_o(ntf_i)
  );

  function automatic logic [AW-1:0] adr(int idx, int esc, int offs);
    return AW'((idx << (PS + 1)) | (esc << PS) | offs);
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: optional request and optional trigger, sampled after the edge
  task automatic step(bit rv, bit wr, logic [AW-1:0] a, logic [3:0] sz,
                      bit tv, int ti);
    @(negedge clk);
    req_v = rv; req_w = wr; req_a = a; req_sz = sz;
    trig_v = tv; trig_i = IW'(ti);
    @(posedge clk); #1;
    req_v = 0; req_w = 0; trig_v = 0;
  endtask

  task automatic ld(int idx, int esc, int offs, logic [63:0] exp, string req);
    step(1, 0, adr(idx, esc, offs), 4'd8, 0, 0);
    chk({req, " rsp_valid R2"}, 64'(rsp_v), 64'd1);
    chk(req, rsp_d, exp);
  endtask

  task automatic get(int idx, int esc, logic [1:0] exp, string req);
    ld(idx, esc, 12'h800, {62'd0, exp}, req);
  endtask

  task automatic trig(int idx, bit exp_ntf, string req);
    step(0, 0, '0, 4'd8, 1, idx);
    chk(req, 64'(ntf), 64'(exp_ntf));
  endtask

  task automatic t_reset;
    chk("R13 rsp_valid", 64'(rsp_v), 64'd0);
    chk("R13 notify", 64'(ntf), 64'd0);
    get(0, 0, 2'b00, "R13 pq reset");
    get(4, 1, 2'b00, "R13 pq reset esc");
    step(0, 0, '0, 4'd8, 0, 0);
    chk("R2 idle no rsp", 64'(rsp_v), 64'd0);
  endtask

  task automatic t_set_get;
    ld(1, 1, 12'hF00, 64'd0, "R5 set11 old");
    get(1, 1, 2'b11, "R5 set11 new");
    get(1, 0, 2'b00, "R1 notify field separate");
    ld(1, 1, 12'hBFF, 64'd3, "R4 get top of window");
    ld(1, 1, 12'hD80, 64'd3, "R5 set01 old");
    get(1, 1, 2'b01, "R5 set01 new");
    ld(1, 1, 12'hE00, 64'd1, "R5 set10 old");
    get(1, 1, 2'b10, "R4 get unchanged");
    get(1, 1, 2'b10, "R4 get repeat");
    ld(0, 1, 12'hC00, 64'd0, "R1 desc0 esc untouched");
  endtask

  task automatic t_eoi;
    ld(0, 0, 12'hF00, 64'd0, "R5 preset 11");
    ld(0, 0, 12'h000, 64'd1, "R3 eoi Q=1 return");
    get(0, 0, 2'b10, "R3 eoi Q=1 state 10");
    ld(0, 0, 12'h7FF, 64'd0, "R3 eoi Q=0 return");
    get(0, 0, 2'b00, "R3 eoi Q=0 state 00");
    ld(0, 0, 12'hD00, 64'd0, "R5 preset 01");
    ld(0, 0, 12'h400, 64'd1, "R3 eoi from 01");
    get(0, 0, 2'b10, "R3 eoi from 01 state");
  endtask

  task automatic t_store;
    step(1, 1, adr(1, 1, 12'hC00), 4'd8, 0, 0);
    chk("R6 store err", 64'(rsp_e), 64'd1);
    chk("R6 store data", rsp_d, 64'd0);
    get(1, 1, 2'b10, "R6 store no change");
  endtask

  task automatic t_size;
    step(1, 0, adr(1, 1, 12'hC00), 4'd4, 0, 0);
    chk("R7 size err", 64'(rsp_e), 64'd1);
    chk("R7 size data", rsp_d, ONES);
    get(1, 1, 2'b10, "R7 size no change");
  endtask

  task automatic t_invalid;
    ld(5, 0, 12'hF00, ONES, "R8 invalid desc set");
    chk("R8 invalid no err", 64'(rsp_e), 64'd0);
    ld(6, 0, 12'h800, ONES, "R8 index out of range");
    ld(7, 1, 12'hF00, ONES, "R8 index 7 out of range");
    dvalid[5] = 1'b1;
    get(5, 0, 2'b00, "R8 invalid desc unchanged");
    dvalid[5] = 1'b0;
  endtask

  task automatic t_trigger;
    trig(3, 1, "R9 00 notifies");
    chk("R9 notify idx", 64'(ntf_i), 64'd3);
    get(3, 0, 2'b10, "R9 00 to 10");
    trig(3, 0, "R9 10 coalesced");
    get(3, 0, 2'b11, "R9 10 to 11");
    trig(3, 0, "R9 11 coalesced");
    get(3, 0, 2'b11, "R9 11 stays");
    ld(3, 0, 12'hD00, 64'd3, "R5 set 01");
    trig(3, 0, "R9 01 no notify");
    get(3, 0, 2'b01, "R9 01 stays");
    get(3, 1, 2'b00, "R9 esc field untouched");
  endtask

  task automatic t_ucond;
    trig(2, 1, "R10 ucond notifies");
    trig(2, 1, "R10 ucond notifies again");
    get(2, 0, 2'b00, "R10 ucond pq unchanged");
  endtask

  task automatic t_trig_invalid;
    trig(5, 0, "R11 invalid desc ignored");
    trig(7, 0, "R11 out of range ignored");
    dvalid[5] = 1'b1;
    get(5, 0, 2'b00, "R11 invalid desc pq unchanged");
    dvalid[5] = 1'b0;
  endtask

  task automatic t_same_cycle;
    ld(4, 0, 12'hF00, 64'd0, "R5 preset 11");
    step(1, 0, adr(4, 0, 12'hC00), 4'd8, 1, 4);
    chk("R12 load return", rsp_d, 64'd3);
    chk("R12 trigger sees load result", 64'(ntf), 64'd1);
    get(4, 0, 2'b10, "R12 final state");
  endtask

  bit timed_out = 0;

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    fork
      begin
        t_reset();
        t_set_get();
        t_eoi();
        t_store();
        t_size();
        t_invalid();
        t_trigger();
        t_ucond();
        t_trig_invalid();
        t_same_cycle();
      end
      begin
        repeat (20000) @(posedge clk);
        timed_out = 1;
      end
    join_any
    if (timed_out) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule